// File: doc/BRIEF.md
# Complementing pattern counter

A synchronous 16-bit test-pattern generator. On each step it replaces its value with the bitwise inverse of that value. It adds one only when the most significant bit of the current value is set. The output therefore alternates between a low number and its mirror image near the top of the range, and the low number creeps forward by one every two steps. This gives richer bit toggling than a plain binary count, which suits pin and bus exercising.

The step rate comes from a built-in prescaler running on the same master clock. A divide counter walks from 1 to `DIV_LIMIT`. When it reaches its limit it restarts at 1 and flips an internal slow phase bit. A step fires in the master cycle where that phase bit falls, so there is one step every `2*DIV_LIMIT` master cycles and the design uses a single clock domain. A seed can be loaded at any time. A synchronous reset clears both the pattern and the prescaler.

Top module: `cpat_gen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `pattern` reads 0 after that edge.
- R2: On a step where `pattern[15]` is 0, the next value is the bitwise inverse of the current value (0 becomes 16'hFFFF, 125 becomes 65410).
- R3: On a step where `pattern[15]` is 1, the next value is the bitwise inverse plus one, modulo 65536. For example, 16'hFFFF becomes 1, and 16'h8000 maps to itself.
- R4: With `DIV_LIMIT` = 16, the first step occurs at the 32nd rising edge after reset is released. Later steps follow every 32 edges.
- R5: Between steps, and with no load, `pattern` holds its value.
- R6: A high `seed_load` at an edge places `seed_value` on `pattern` after that edge, and this overrides a step in the same cycle.
- R7: Reset overrides a seed load in the same cycle.
- R8: After loading seed 125, the successive output values are 125, 65410, 126, 65409, 127, 65408.
- R9: A seed load does not disturb the prescaler: steps keep their 32-edge spacing counted from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_value` into the pattern register |
| seed_value | input | 16 | Value to load |
| pattern | output | 16 | Registered pattern value |

## Verification
Every result is due one rising edge after the cause: a load or a reset shows on `pattern` after the edge that samples it. A step shows after the 32nd edge counted from reset release, and every 32 edges after that. The bench keeps a behavioural model that counts edges since reset and applies loads and steps at those same edges. The bench drives inputs and compares every output on falling edges, so each compare sees the value settled after exactly the edges the model has counted. Separate explicit checks sample the cycle just before and just after the first step, and sample each change of the seed-125 trace.

// File: rtl/cpat_gen.sv
module cpat_gen #(
  parameter int WIDTH     = 16,
  parameter int DIV_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  output logic [WIDTH-1:0] pattern
);
  localparam int DW = $clog2(DIV_LIMIT + 1);
  localparam logic [DW-1:0] DIV_END = DW'(DIV_LIMIT);
  localparam logic [DW-1:0] DIV_ONE = DW'(1);

  logic [DW-1:0]    div_cnt;
  logic             slow_ph;
  logic             step;
  logic [WIDTH-1:0] next_val;

  assign step     = (div_cnt == DIV_END) && slow_ph;
  assign next_val = ~pattern + WIDTH'(pattern[WIDTH-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= DIV_ONE;
      slow_ph <= 1'b0;
    end else if (div_cnt == DIV_END) begin
      div_cnt <= DIV_ONE;
      slow_ph <= ~slow_ph;
    end else begin
      div_cnt <= div_cnt + DIV_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            pattern <= '0;
    else if (seed_load) pattern <= seed_value;
    else if (step)      pattern <= next_val;
  end
endmodule

module cpat_gen_chk #(
  parameter int WIDTH     = 16,
  parameter int DIV_LIMIT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_value,
  input logic [WIDTH-1:0] pattern,
  input logic             step
);
  int gap;

  always_ff @(posedge clk) begin
    if (rst || step) gap <= 0;
    else             gap <= gap + 1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> pattern == '0);

  p_step_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && step && !pattern[WIDTH-1]) |=> pattern == ~$past(pattern));

  p_step_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && step && pattern[WIDTH-1]) |=> pattern == WIDTH'(~$past(pattern) + 1'b1));

  p_step_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    step |-> gap == 2 * DIV_LIMIT - 1);

  p_step_due_r9: assert property (@(posedge clk) disable iff (rst)
    (gap == 2 * DIV_LIMIT - 1) |-> step);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !step) |=> $stable(pattern));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> pattern == $past(seed_value));
endmodule

bind cpat_gen cpat_gen_chk #(.WIDTH(WIDTH), .DIV_LIMIT(DIV_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
  .pattern(pattern), .step(step)
);

// File: tb/cpat_gen_tb.sv
module cpat_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [15:0] seed_value = '0;
  logic [15:0] pattern;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  int    m_val = 0;
  int    m_ph = 0;
  bit    model_on = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cpat_gen u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load),
    .seed_value(seed_value), .pattern(pattern)
  );

  function automatic int rec_next(int v);
    int inv;
    inv = (~v) & 16'hFFFF;
    if (v >= 32768) inv = (inv + 1) % 65536;
    return inv;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_val = 0;
      m_ph  = 0;
    end else begin
      m_ph++;
      if (seed_load)          m_val = seed_value;
      else if (m_ph % 32 == 0) m_val = rec_next(m_val);
    end
    model_on = 1;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  always @(negedge clk)
    if (model_on) check(cur_req, int'(pattern), m_val);

  task automatic load(int v);
    @(negedge clk);
    seed_load  = 1'b1;
    seed_value = 16'(v);
    @(negedge clk);
    seed_load  = 1'b0;
  endtask

  int trace[6] = '{125, 65410, 126, 65409, 127, 65408};

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", int'(pattern), 0);

    cur_req = "R4";
    rst = 1'b0;
    repeat (31) @(negedge clk);
    check("R4", int'(pattern), 0);
    @(negedge clk);
    check("R2", int'(pattern), 16'hFFFF);
    repeat (32) @(negedge clk);
    check("R3", int'(pattern), 1);

    cur_req = "R5";
    repeat (10) @(negedge clk);

    cur_req = "R8";
    load(125);
    check("R6", int'(pattern), 125);
    for (int k = 1; k < 6; k++) begin
      int prev;
      prev = int'(pattern);
      while (int'(pattern) == prev) @(negedge clk);
      check("R8", int'(pattern), trace[k]);
    end

    cur_req = "R3";
    load(16'h8000);
    repeat (70) @(negedge clk);
    check("R3", int'(pattern), 16'h8000);

    load(16'hFFFF);
    while (int'(pattern) == 16'hFFFF) @(negedge clk);
    check("R3", int'(pattern), 1);

    cur_req = "R6";
    @(negedge clk);
    seed_load  = 1'b1;
    seed_value = 16'h1234;
    repeat (70) @(negedge clk);
    check("R6", int'(pattern), 16'h1234);
    seed_load = 1'b0;

    cur_req = "R9";
    repeat (13) @(negedge clk);
    load(16'h00F0);
    repeat (80) @(negedge clk);

    cur_req = "R7";
    @(negedge clk);
    rst        = 1'b1;
    seed_load  = 1'b1;
    seed_value = 16'hABCD;
    @(negedge clk);
    check("R7", int'(pattern), 0);
    seed_load = 1'b0;
    rst = 1'b0;
    cur_req = "R4";
    repeat (31) @(negedge clk);
    check("R4", int'(pattern), 0);
    @(negedge clk);
    check("R4", int'(pattern), 16'hFFFF);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule